// File: doc/BRIEF.md
# SDRAM Bank-Interleaving Command Scheduler

This block turns an in-order stream of single-word read and write requests into SDRAM command sequences. Each request gives a bank, a row, a column, write data, a byte mask and a tag. Every access opens its row with an Active command. It then issues a Read or Write once the row-to-column delay has passed, with the auto-precharge bit set, so the bank closes by itself. While one bank is still writing back or precharging, the next request to a different bank can already open its row. Active and column commands to separate banks therefore fill the command slots back to back.

The scheduler issues commands only on alternate cycles, starting with the first edge after reset, so every access lines up on a two-cycle grid. A write that follows a read is held back by two command slots beyond the tightest packing. This stops the controller from driving the data bus next to the cycle in which the memory returns read data. A read that follows a write needs no such hold. Read data is sampled after the CAS latency and handed back with its tag. Refresh, power-up sequencing, arbitration between ports and I/O phase tuning belong to other blocks.

Top module: `sdram_sched`

## Requirements
- R1: While reset is held, the command pins show NOP ({RAS#,CAS#,WE#} = 3'b111), the DQ output enable is low and rdValid is low. After reset, reqReady is high with no request pending.
- R2: An accepted request produces an Active command ({RAS#,CAS#,WE#} = 3'b011) one cycle after acceptance, with the request's bank on sdBa and its row on sdAddr. Requests are served in arrival order.
- R3: The Read (3'b101) or Write (3'b100) for a request comes at least T_RCD (2) cycles after its Active, to the same bank. sdAddr bit 10 is high (auto-precharge) and the column sits in the low sdAddr bits.
- R4: In a Write cycle, sdDqOut carries the request's data and sdDqm carries its byte mask, where mask bit k high blocks byte k. In a Read cycle, sdDqm is all zero.
- R5: sdDqOe is high only in the cycle of a Write command; at all other times the data bus is released.
- R6: rdValid pulses for one cycle, CAS_LAT+1 (3) cycles after the cycle of the Read command. rdData is sdDqIn as sampled at the end of cycle Read+CAS_LAT, and rdTag is the request's tag.
- R7: After a column command, the same bank gets no new Active for T_WR+T_RP (4) cycles after a Write, or 1+T_RP (3) cycles after a Read. Until then, reqReady stays low for a request to that bank.
- R8: A Write command comes at least 6 cycles after the previous Read command, which is two slots beyond tight packing. sdDqOe is never high within one cycle of the cycle in which the memory returns read data.
- R9: A Read that follows a Write to another bank needs no extra gap: with the request waiting, its Read comes 4 cycles after the Write.
- R10: Every command falls on an even cycle, counting the first edge after reset as cycle 0, and no two commands are in adjacent cycles.
- R11: The data returned by each read equals what the preceding writes put in that location, with masked bytes left unchanged.
- R12: An Active to a different bank may be issued while the previous bank is still busy. With a request waiting, it follows the previous column command by 2 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Request accepted at this edge when high with reqValid |
| reqWrite | input | 1 | 1 for write, 0 for read |
| reqBank | input | BANK_W | Target bank |
| reqRow | input | ROW_W | Row address |
| reqCol | input | COL_W | Column address |
| reqWdata | input | DATA_W | Write data |
| reqMask | input | DATA_W/8 | Byte mask, bit high blocks that byte |
| reqTag | input | TAG_W | Tag returned with read data |
| sdRasN | output | 1 | Row strobe, active low |
| sdCasN | output | 1 | Column strobe, active low |
| sdWeN | output | 1 | Write enable, active low |
| sdBa | output | BANK_W | Bank address |
| sdAddr | output | ROW_W | Row / column address, bit 10 auto-precharge |
| sdDqm | output | DATA_W/8 | Byte masks |
| sdDqOut | output | DATA_W | Write data to the DQ pads |
| sdDqOe | output | 1 | DQ pad output enable |
| sdDqIn | input | DATA_W | Read data from the DQ pads |
| rdValid | output | 1 | Read data valid pulse |
| rdData | output | DATA_W | Read data |
| rdTag | output | TAG_W | Tag of the returned read |

## Verification
The Active appears in the cycle after the edge that accepts a request. The column command follows on the next free even cycle that meets T_RCD, the bank hold and the read-to-write hold. rdValid rises exactly CAS_LAT+1 cycles after the Read cycle. A memory model in the bench samples the command pins on the falling edge and numbers each cycle from the first edge after reset. It drives sdDqIn only in the cycle the returned data is due, so a capture one cycle early or late picks up a marker value. Every command seen on the pins is checked against its expected spacing in cycles, and each read result is compared when it appears against the queue of expected data and tags.

// File: rtl/sdram_sched_pkg.sv
`timescale 1ns/1ps
package sdram_sched_pkg;

  // command pin triple {RAS#, CAS#, WE#}
  typedef enum logic [2:0] {
    CMD_ACT = 3'b011,
    CMD_RD  = 3'b101,
    CMD_WR  = 3'b100,
    CMD_NOP = 3'b111
  } sdCmd_t;

  // strobes from control to datapath
  typedef struct packed {
    logic actStb;   // launch Active from the request and latch it as pending
    logic casStb;   // launch the pending column command
  } schedStrobe_t;

endpackage

// File: rtl/sdram_sched_banks.sv
`timescale 1ns/1ps
module sdram_sched_banks #(
  parameter int NUM_BANKS = 4,
  parameter int BANK_W    = 2,
  parameter int T_WR      = 2,
  parameter int T_RP      = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 actStb,
  input  logic [BANK_W-1:0]    actBank,
  input  logic                 casStb,
  input  logic                 casWrite,
  input  logic [BANK_W-1:0]    casBank,
  output logic [NUM_BANKS-1:0] bankBusy
);

  localparam int RD_HOLD  = 1 + T_RP;
  localparam int WR_HOLD  = T_WR + T_RP;
  localparam int HOLD_MAX = (RD_HOLD > WR_HOLD) ? RD_HOLD : WR_HOLD;
  localparam int CNT_W    = $clog2(HOLD_MAX + 1) + 1;

  for (genvar g = 0; g < NUM_BANKS; g++) begin : gBank
    logic             openQ;
    logic [CNT_W-1:0] holdQ;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        openQ <= 1'b0;
        holdQ <= '0;
      end else begin
        if (actStb && actBank == BANK_W'(g)) openQ <= 1'b1;
        if (casStb && casBank == BANK_W'(g)) begin
          openQ <= 1'b0;
          holdQ <= casWrite ? CNT_W'(WR_HOLD) : CNT_W'(RD_HOLD);
        end else if (holdQ != '0) begin
          holdQ <= holdQ - CNT_W'(1);
        end
      end
    end

    // a count of 1 means the hold ends at the coming edge
    assign bankBusy[g] = openQ || (holdQ > CNT_W'(1));

    AST_ACT_FREE: assert property (@(posedge clk) disable iff (!rstN)
      (actStb && actBank == BANK_W'(g)) |-> !(openQ || holdQ > CNT_W'(1))); // R7
  end

endmodule

// File: rtl/sdram_sched_ctrl.sv
`timescale 1ns/1ps
module sdram_sched_ctrl
  import sdram_sched_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int BANK_W    = 2,
  parameter int T_RCD     = 2,
  parameter int CAS_LAT   = 2,
  parameter int TURN_GAP  = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 reqValid,
  input  logic [BANK_W-1:0]    reqBank,
  input  logic [NUM_BANKS-1:0] bankBusy,
  input  logic                 pendWrite,
  output logic                 reqReady,
  output schedStrobe_t         strb
);

  // read-to-write hold in cycles: tight packing is one slot, plus the gap,
  // and never less than what keeps DQ clear of the returned data
  localparam int RD2WR_SLOT = 2 * (1 + TURN_GAP);
  localparam int RD2WR_DATA = ((CAS_LAT + 5) / 2) * 2;
  localparam int RD2WR      = (RD2WR_SLOT > RD2WR_DATA) ? RD2WR_SLOT : RD2WR_DATA;
  localparam int RCD_W      = $clog2(T_RCD + 1) + 1;
  localparam int TURN_W     = $clog2(RD2WR + 1) + 1;

  logic              slotQ;
  logic              pendValidQ;
  logic [RCD_W-1:0]  rcdCntQ;
  logic [TURN_W-1:0] turnCntQ;
  logic              casOk;

  always_comb begin
    casOk = pendValidQ && !slotQ && (rcdCntQ <= RCD_W'(1)) &&
            (!pendWrite || (turnCntQ <= TURN_W'(1)));
    reqReady    = !slotQ && !pendValidQ && !bankBusy[reqBank];
    strb.actStb = reqValid && reqReady;
    strb.casStb = casOk;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      slotQ      <= 1'b0;
      pendValidQ <= 1'b0;
      rcdCntQ    <= '0;
      turnCntQ   <= '0;
    end else begin
      slotQ <= !slotQ;
      if (strb.actStb)      pendValidQ <= 1'b1;
      else if (strb.casStb) pendValidQ <= 1'b0;

      if (strb.actStb)          rcdCntQ <= RCD_W'(T_RCD);
      else if (rcdCntQ != '0)   rcdCntQ <= rcdCntQ - RCD_W'(1);

      if (strb.casStb && !pendWrite) turnCntQ <= TURN_W'(RD2WR);
      else if (turnCntQ != '0)       turnCntQ <= turnCntQ - TURN_W'(1);
    end
  end

  AST_STALL_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && bankBusy[reqBank]) |-> !reqReady); // R7

endmodule

// File: rtl/sdram_sched_dp.sv
`timescale 1ns/1ps
module sdram_sched_dp
  import sdram_sched_pkg::*;
#(
  parameter int BANK_W  = 2,
  parameter int ROW_W   = 13,
  parameter int COL_W   = 9,
  parameter int DATA_W  = 16,
  parameter int TAG_W   = 4,
  parameter int CAS_LAT = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  schedStrobe_t         strb,
  input  logic                 reqWrite,
  input  logic [BANK_W-1:0]    reqBank,
  input  logic [ROW_W-1:0]     reqRow,
  input  logic [COL_W-1:0]     reqCol,
  input  logic [DATA_W-1:0]    reqWdata,
  input  logic [DATA_W/8-1:0]  reqMask,
  input  logic [TAG_W-1:0]     reqTag,
  output logic                 pendWrite,
  output logic [BANK_W-1:0]    pendBank,
  output logic                 sdRasN,
  output logic                 sdCasN,
  output logic                 sdWeN,
  output logic [BANK_W-1:0]    sdBa,
  output logic [ROW_W-1:0]     sdAddr,
  output logic [DATA_W/8-1:0]  sdDqm,
  output logic [DATA_W-1:0]    sdDqOut,
  output logic                 sdDqOe,
  input  logic [DATA_W-1:0]    sdDqIn,
  output logic                 rdValid,
  output logic [DATA_W-1:0]    rdData,
  output logic [TAG_W-1:0]     rdTag
);

  localparam int MASK_W = DATA_W / 8;
  localparam int AP_BIT = 10;
  localparam int PIPE_N = CAS_LAT + 2;   // one guard stage past capture

  logic [COL_W-1:0]  pCol;
  logic [DATA_W-1:0] pData;
  logic [MASK_W-1:0] pMask;
  logic [TAG_W-1:0]  pTag;
  sdCmd_t            cmdQ;
  logic [ROW_W-1:0]  colAddr;
  logic [PIPE_N-1:0] rdPipe;
  logic [TAG_W-1:0]  tagPipe [PIPE_N];

  always_comb begin
    colAddr           = '0;
    colAddr[COL_W-1:0] = pCol;
    colAddr[AP_BIT]   = 1'b1;
  end

  // pending request
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendWrite <= 1'b0;
      pendBank  <= '0;
      pCol      <= '0;
      pData     <= '0;
      pMask     <= '0;
      pTag      <= '0;
    end else if (strb.actStb) begin
      pendWrite <= reqWrite;
      pendBank  <= reqBank;
      pCol      <= reqCol;
      pData     <= reqWdata;
      pMask     <= reqMask;
      pTag      <= reqTag;
    end
  end

  // command and pad registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdQ    <= CMD_NOP;
      sdBa    <= '0;
      sdAddr  <= '0;
      sdDqm   <= '0;
      sdDqOut <= '0;
      sdDqOe  <= 1'b0;
    end else if (strb.actStb) begin
      cmdQ   <= CMD_ACT;
      sdBa   <= reqBank;
      sdAddr <= reqRow;
      sdDqOe <= 1'b0;
    end else if (strb.casStb) begin
      cmdQ    <= pendWrite ? CMD_WR : CMD_RD;
      sdBa    <= pendBank;
      sdAddr  <= colAddr;
      sdDqm   <= pendWrite ? pMask : '0;
      sdDqOut <= pData;
      sdDqOe  <= pendWrite;
    end else begin
      cmdQ   <= CMD_NOP;
      sdDqOe <= 1'b0;
    end
  end

  assign {sdRasN, sdCasN, sdWeN} = cmdQ;

  // read return pipeline: stage k holds a read whose command edge was k edges ago
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdPipe  <= '0;
      rdValid <= 1'b0;
      rdData  <= '0;
      rdTag   <= '0;
      for (int i = 0; i < PIPE_N; i++) tagPipe[i] <= '0;
    end else begin
      rdPipe     <= {rdPipe[PIPE_N-2:0], strb.casStb && !pendWrite};
      tagPipe[0] <= pTag;
      for (int i = 1; i < PIPE_N; i++) tagPipe[i] <= tagPipe[i-1];
      rdValid <= rdPipe[CAS_LAT];
      if (rdPipe[CAS_LAT]) begin
        rdData <= sdDqIn;
        rdTag  <= tagPipe[CAS_LAT];
      end
    end
  end

  AST_CMD_SPACED: assert property (@(posedge clk) disable iff (!rstN)
    (!sdRasN || !sdCasN) |=> (sdRasN && sdCasN)); // R10

  AST_OE_ONLY_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    sdDqOe |-> (sdRasN && !sdCasN && !sdWeN)); // R5

  AST_A10_SET: assert property (@(posedge clk) disable iff (!rstN)
    (sdRasN && !sdCasN) |-> sdAddr[AP_BIT]); // R3

  AST_NO_TURN_CLASH: assert property (@(posedge clk) disable iff (!rstN)
    sdDqOe |-> (rdPipe == '0)); // R8

endmodule

// File: rtl/sdram_sched.sv
`timescale 1ns/1ps
module sdram_sched
  import sdram_sched_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int ROW_W     = 13,
  parameter int COL_W     = 9,
  parameter int DATA_W    = 16,
  parameter int TAG_W     = 4,
  parameter int T_RCD     = 2,
  parameter int T_WR      = 2,
  parameter int T_RP      = 2,
  parameter int CAS_LAT   = 2,
  parameter int TURN_GAP  = 2,
  localparam int BANK_W   = $clog2(NUM_BANKS),
  localparam int MASK_W   = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqWrite,
  input  logic [BANK_W-1:0] reqBank,
  input  logic [ROW_W-1:0]  reqRow,
  input  logic [COL_W-1:0]  reqCol,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [MASK_W-1:0] reqMask,
  input  logic [TAG_W-1:0]  reqTag,
  output logic              sdRasN,
  output logic              sdCasN,
  output logic              sdWeN,
  output logic [BANK_W-1:0] sdBa,
  output logic [ROW_W-1:0]  sdAddr,
  output logic [MASK_W-1:0] sdDqm,
  output logic [DATA_W-1:0] sdDqOut,
  output logic              sdDqOe,
  input  logic [DATA_W-1:0] sdDqIn,
  output logic              rdValid,
  output logic [DATA_W-1:0] rdData,
  output logic [TAG_W-1:0]  rdTag
);

  schedStrobe_t          strb;
  logic                  pendWrite;
  logic [BANK_W-1:0]     pendBank;
  logic [NUM_BANKS-1:0]  bankBusy;

  sdram_sched_banks #(
    .NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W), .T_WR(T_WR), .T_RP(T_RP)
  ) banks_i (
    .clk(clk), .rstN(rstN),
    .actStb(strb.actStb), .actBank(reqBank),
    .casStb(strb.casStb), .casWrite(pendWrite), .casBank(pendBank),
    .bankBusy(bankBusy)
  );

  sdram_sched_ctrl #(
    .NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W), .T_RCD(T_RCD),
    .CAS_LAT(CAS_LAT), .TURN_GAP(TURN_GAP)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqBank(reqBank),
    .bankBusy(bankBusy), .pendWrite(pendWrite), .reqReady(reqReady), .strb(strb)
  );

  sdram_sched_dp #(
    .BANK_W(BANK_W), .ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W),
    .TAG_W(TAG_W), .CAS_LAT(CAS_LAT)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb),
    .reqWrite(reqWrite), .reqBank(reqBank), .reqRow(reqRow), .reqCol(reqCol),
    .reqWdata(reqWdata), .reqMask(reqMask), .reqTag(reqTag),
    .pendWrite(pendWrite), .pendBank(pendBank),
    .sdRasN(sdRasN), .sdCasN(sdCasN), .sdWeN(sdWeN), .sdBa(sdBa), .sdAddr(sdAddr),
    .sdDqm(sdDqm), .sdDqOut(sdDqOut), .sdDqOe(sdDqOe), .sdDqIn(sdDqIn),
    .rdValid(rdValid), .rdData(rdData), .rdTag(rdTag)
  );

endmodule

// File: tb/sdram_sched_tb_top.sv
`timescale 1ns/1ps
module sdram_sched_tb_top;

  localparam int CL = 2, TRCD = 2, WR_HOLD = 4, RD_HOLD = 3, RD2WR = 6;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rstN = 1'b0;
  logic        reqValid = 1'b0, reqWrite = 1'b0;
  logic        reqReady;
  logic [1:0]  reqBank = '0;
  logic [12:0] reqRow = '0;
  logic [8:0]  reqCol = '0;
  logic [15:0] reqWdata = '0;
  logic [1:0]  reqMask = '0;
  logic [3:0]  reqTag = '0;
  logic        sdRasN, sdCasN, sdWeN, sdDqOe, rdValid;
  logic [1:0]  sdBa, sdDqm;
  logic [12:0] sdAddr;
  logic [15:0] sdDqOut, rdData;
  logic [15:0] sdDqIn = 16'hDEAD;
  logic [3:0]  rdTag;

  sdram_sched dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqBank(reqBank), .reqRow(reqRow), .reqCol(reqCol),
    .reqWdata(reqWdata), .reqMask(reqMask), .reqTag(reqTag),
    .sdRasN(sdRasN), .sdCasN(sdCasN), .sdWeN(sdWeN), .sdBa(sdBa), .sdAddr(sdAddr),
    .sdDqm(sdDqm), .sdDqOut(sdDqOut), .sdDqOe(sdDqOe), .sdDqIn(sdDqIn),
    .rdValid(rdValid), .rdData(rdData), .rdTag(rdTag)
  );

  typedef struct { bit wr; int bank; int row; int col; logic [15:0] data; logic [1:0] mask; } op_t;
  typedef struct { logic [3:0] tag; logic [15:0] data; } rd_t;

  op_t  actQ[$];
  op_t  casQ[$];
  rd_t  rdQ[$];
  int   rdCycQ[$];

  int checks = 0, errors = 0;
  int cyc = -1;
  logic [15:0] refMem [32];
  logic [15:0] modelMem [32];
  int   openRow [4];
  int   lastAct [4];
  int   lastCas [4];
  bit   lastCasWr [4];
  int   lastCmd = -10, lastRd = -100;
  bit   bRdV [CL+2];
  logic [15:0] bRdD [CL+2];
  logic [3:0] tagCnt = '0;

  always @(posedge clk) cyc <= rstN ? cyc + 1 : -1;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int idxOf(int b, int r, int c);
    return b * 8 + (r % 2) * 4 + (c % 4);
  endfunction

  // ---------------- memory model and monitor ----------------
  always @(negedge clk) begin
    logic [2:0] cmd;
    op_t o;
    cmd = {sdRasN, sdCasN, sdWeN};
    if (!rstN) begin
      chk(cmd == 3'b111, "R1", "cmd in reset", cmd, 3'b111);
      chk(!sdDqOe && !rdValid, "R1", "oe/rdValid in reset", {sdDqOe, rdValid}, 0);
    end else begin
      for (int i = CL + 1; i > 0; i--) begin bRdV[i] = bRdV[i-1]; bRdD[i] = bRdD[i-1]; end
      bRdV[0] = 1'b0;
      if (cmd != 3'b111) begin
        chk(cyc % 2 == 0, "R10", "command parity", cyc, 0);
        chk(cyc - lastCmd >= 2, "R10", "command spacing", cyc - lastCmd, 2);
        lastCmd = cyc;
      end
      if (cmd == 3'b011) begin
        o = actQ.pop_front();
        chk(sdBa == o.bank && sdAddr == o.row, "R2", "active bank/row", {sdBa, sdAddr}, {o.bank[1:0], o.row[12:0]});
        if (lastCas[sdBa] > -100)
          chk(cyc - lastCas[sdBa] >= (lastCasWr[sdBa] ? WR_HOLD : RD_HOLD), "R7",
              "bank reuse gap", cyc - lastCas[sdBa], lastCasWr[sdBa] ? WR_HOLD : RD_HOLD);
        lastAct[sdBa] = cyc;
        openRow[sdBa] = int'(sdAddr);
      end else if (cmd == 3'b101 || cmd == 3'b100) begin
        o = casQ.pop_front();
        chk(sdBa == o.bank && sdAddr[10] && sdAddr[8:0] == o.col && (cmd == 3'b100) == o.wr,
            "R3", "column command", {cmd, sdBa, sdAddr}, {(o.wr ? 3'b100 : 3'b101), o.bank[1:0], 4'b0100, o.col[8:0]});
        chk(cyc - lastAct[sdBa] >= TRCD, "R3", "row to column delay", cyc - lastAct[sdBa], TRCD);
        if (cmd == 3'b100) begin
          chk(sdDqOe && sdDqOut == o.data && sdDqm == o.mask, "R4", "write data/mask",
              {sdDqOe, sdDqm, sdDqOut}, {1'b1, o.mask, o.data});
          chk(cyc - lastRd >= RD2WR, "R8", "read to write gap", cyc - lastRd, RD2WR);
          for (int k = 0; k < 2; k++)
            if (!sdDqm[k]) modelMem[idxOf(sdBa, openRow[sdBa], sdAddr)][8*k +: 8] = sdDqOut[8*k +: 8];
          lastCasWr[sdBa] = 1'b1;
        end else begin
          chk(sdDqm == 2'b00, "R4", "read dqm", sdDqm, 0);
          bRdV[0] = 1'b1;
          bRdD[0] = modelMem[idxOf(sdBa, openRow[sdBa], sdAddr)];
          rdCycQ.push_back(cyc);
          lastRd = cyc;
          lastCasWr[sdBa] = 1'b0;
        end
        lastCas[sdBa] = cyc;
      end
      if (sdDqOe) begin
        chk(cmd == 3'b100, "R5", "oe outside write", cmd, 3'b100);
        chk(!(bRdV[CL-1] || bRdV[CL] || bRdV[CL+1]), "R8", "dq contention", 1, 0);
      end
      sdDqIn = bRdV[CL] ? bRdD[CL] : 16'hDEAD;
      if (rdValid) begin
        rd_t e;
        int c;
        if (rdQ.size() == 0) chk(1'b0, "R11", "unexpected read data", rdData, 0);
        else begin
          e = rdQ.pop_front();
          c = rdCycQ.pop_front();
          chk(rdTag == e.tag && rdData == e.data, "R11", "read tag/data", {rdTag, rdData}, {e.tag, e.data});
          chk(cyc - c == CL + 1, "R6", "read latency", cyc - c, CL + 1);
        end
      end
    end
  end

  // ---------------- driver ----------------
  task automatic doReq(input bit wr, input int b, input int r, input int c,
                       input logic [15:0] d, input logic [1:0] m);
    op_t o;
    int ix;
    @(negedge clk);
    o.wr = wr; o.bank = b; o.row = r; o.col = c; o.data = d; o.mask = wr ? m : 2'b00;
    actQ.push_back(o);
    casQ.push_back(o);
    ix = idxOf(b, r, c);
    if (wr) begin
      for (int k = 0; k < 2; k++) if (!m[k]) refMem[ix][8*k +: 8] = d[8*k +: 8];
    end else begin
      rdQ.push_back('{tag: tagCnt, data: refMem[ix]});
    end
    reqValid = 1'b1; reqWrite = wr; reqBank = 2'(b); reqRow = 13'(r); reqCol = 9'(c);
    reqWdata = d; reqMask = m; reqTag = tagCnt;
    tagCnt++;
    #0.5;
    while (!reqReady) begin @(posedge clk); #0.5; end
    @(posedge clk);
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    reqValid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    for (int i = 0; i < 32; i++) begin refMem[i] = '0; modelMem[i] = '0; end
    for (int b = 0; b < 4; b++) begin lastAct[b] = -100; lastCas[b] = -100; lastCasWr[b] = 0; openRow[b] = 0; end
    for (int i = 0; i < CL + 2; i++) begin bRdV[i] = 0; bRdD[i] = '0; end
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    #0.5;
    chk(reqReady == 1'b1, "R1", "ready after reset", reqReady, 1);

    // R12: write bank0 then bank1, second Active two cycles after first Write
    doReq(1, 0, 0, 1, 16'hA5A5, 2'b00);
    doReq(1, 1, 0, 2, 16'h5A5A, 2'b00);
    idle(6);
    chk(lastAct[1] - lastCas[0] == 2, "R12", "overlapped active", lastAct[1] - lastCas[0], 2);

    // R9: write bank2 then read bank3, no extra gap
    doReq(1, 2, 1, 3, 16'h1234, 2'b00);
    doReq(0, 3, 0, 0, 16'h0, 2'b00);
    idle(8);
    chk(lastCas[3] - lastCas[2] == 4, "R9", "write then read spacing", lastCas[3] - lastCas[2], 4);

    // R8: read bank0 then write bank1, write held back
    doReq(0, 0, 0, 1, 16'h0, 2'b00);
    doReq(1, 1, 1, 0, 16'hBEEF, 2'b00);
    idle(10);
    chk(lastCas[1] - lastCas[0] >= RD2WR, "R8", "read then write spacing", lastCas[1] - lastCas[0], RD2WR);

    // R7: same bank back to back write, write, read
    doReq(1, 2, 0, 0, 16'hC0DE, 2'b00);
    doReq(1, 2, 0, 0, 16'hFF00, 2'b01);   // R4 low byte masked
    doReq(0, 2, 0, 0, 16'h0, 2'b00);
    idle(10);
    chk(refMem[idxOf(2, 0, 0)] == 16'hFFDE, "R4", "masked merge", refMem[idxOf(2, 0, 0)], 16'hFFDE);

    // R11: mixed stream across banks
    for (int i = 0; i < 40; i++)
      doReq(i % 3 != 1, i % 4, (i / 4) % 2, (i * 3) % 4, 16'(16'h1000 + i * 37),
            (i % 5 == 0) ? 2'b01 : 2'b00);
    for (int i = 0; i < 32; i++) doReq(0, i / 8, (i / 4) % 2, i % 4, 16'h0, 2'b00);
    idle(2);

    for (int n = 0; n < 200 && rdQ.size() != 0; n++) @(negedge clk);
    chk(rdQ.size() == 0 && casQ.size() == 0, "R11", "all requests completed",
        rdQ.size() + casQ.size(), 0);
    summary();
    $finish;
  end

endmodule